// File: doc/BRIEF.md
# Indexed Register Window with Interrupt Pending Logic

This block is the host-facing register front end of an audio controller. The host sees six word slots. Five of them hold registers: a pointer, a data port, an interrupt pending word, an interrupt enable word and a configuration word. The pointer names one location in a larger indexed register space by a 12-bit register address and a 2-bit channel number. Reads and writes of the data port then reach that location. Indexed addresses 0x00 to 0x3F are a plain storage file with one 32-bit word per channel. A few higher indexed addresses expose two free-running sample-rate counters and their interval settings.

Event inputs and the two timers set single-bit pending flags. The host clears a flag by writing a 1 to it. One level interrupt output is high while any pending flag is set together with its enable bit. Each counter advances on its own one-cycle tick input, one for the fast 192 kHz rate and one for the slow 44.1 kHz rate. Its timer raises a pending flag every time the number of ticks since its last event reaches a programmed interval.

Top module: `idxwin_top`

## Requirements
- R1: Word slots are decoded from `bus_word`: 0 pointer, 1 data port, 2 pending, 3 enable, 5 configuration. Slots 4, 6 and 7 read as zero and ignore writes. A read access updates `bus_rdata` in the cycle after the access, and `bus_rdata` then holds until the next read.
- R2: The pointer keeps the channel in bits [1:0] and the register address in bits [27:16]. All other pointer bits read zero. Half-enable bit 0 writes the lower 16-bit half and bit 1 writes the upper half, each without touching the other half.
- R3: A data-port write stores all 32 bits of `bus_wdata` at the location the pointer names, whatever the half enables. A data-port read returns that location. Each channel of an address is a separate word. Indexed addresses with no function read zero and ignore writes.
- R4: After reset, every indexed location 0x00 to 0x3F reads zero in all four channels, and the pointer, pending, enable and configuration words read zero.
- R5: Writing the pending slot clears each bit written as 1 within the enabled halves. Bits written as 0, or lying in a half that is not enabled, keep their value.
- R6: A high bit on `ext_evt` sets the matching pending bit. If a set and a host clear reach the same bit in the same cycle, the bit stays set.
- R7: Indexed address 0x77 reads the fast counter and 0x78 reads the slow counter, for any channel. Each counter is 22 bits wide, advances by one per tick of its own tick input and wraps from 0x3FFFFF to 0. A data-port write to either address loads that counter, and the load takes priority over a tick in the same cycle.
- R8: Indexed address 0x79 holds the fast interval in channel 0 and the slow interval in channel 1, 22 bits each. Writing an interval restarts that timer's tick count. When a tick brings the ticks since the last event (or since the interval write) up to the interval, pending bit 4 (fast) or bit 3 (slow) is set. An interval of zero produces no events.
- R9: `irq` is high exactly while some pending bit and the same enable bit are both 1.
- R10: The enable and configuration words are read/write storage. A write changes only the enabled halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Word slot index |
| bus_half_en | input | 2 | Half enables for writes: bit 0 lower, bit 1 upper |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ext_evt | input | 32 | Event pulses that set pending bits |
| tick_fast | input | 1 | Fast-rate counter tick |
| tick_slow | input | 1 | Slow-rate counter tick |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives an event and a host clear at the same pending bit in the same cycle. A design that let the clear win would lose that event. It also writes the pending slot with zeros and with only the lower half enabled, which would expose a clear that ignored the written value or the half enables. Pointer half writes are checked for leakage into the other field, and both channels of one address are checked for aliasing. The timers are driven to exactly one tick before and one tick at their interval, and across the 22-bit wrap after a counter load, where an off-by-one count or a missing restart on an interval write would move or drop the pending flag.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

    localparam int DW   = 32;
    localparam int PA_W = 12;

    localparam logic [2:0] W_PTR  = 3'd0;
    localparam logic [2:0] W_DATA = 3'd1;
    localparam logic [2:0] W_PEND = 3'd2;
    localparam logic [2:0] W_EN   = 3'd3;
    localparam logic [2:0] W_CFG  = 3'd5;

    localparam logic [PA_W-1:0] IX_CNT_FAST = 12'h077;
    localparam logic [PA_W-1:0] IX_CNT_SLOW = 12'h078;
    localparam logic [PA_W-1:0] IX_INTERVAL = 12'h079;

    localparam int BIT_SLOW = 3;
    localparam int BIT_FAST = 4;

    typedef struct packed {
        logic [PA_W-1:0] addr;
        logic [1:0]      chan;
    } ptr_t;

    typedef struct packed {
        ptr_t          ptr;
        logic [DW-1:0] en;
        logic [DW-1:0] cfg;
        logic [DW-1:0] rdata;
    } win_st_t;

endpackage

// File: rtl/idxwin_timer.sv
module idxwin_timer #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic             intv_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] interval,
    output logic             evt
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] since;
        logic [CNT_W-1:0] intv;
    } tmr_st_t;

    tmr_st_t q, d;

    always_comb begin
        d   = q;
        evt = tick && (q.intv != '0) && ((q.since + CNT_W'(1)) == q.intv);
        if (tick) begin
            d.count = q.count + CNT_W'(1);
            d.since = evt ? '0 : q.since + CNT_W'(1);
        end
        if (cnt_we) begin
            d.count = wdata;
        end
        if (intv_we) begin
            d.intv  = wdata;
            d.since = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count    = q.count;
    assign interval = q.intv;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we) |=> (q.count == $past(q.count) + CNT_W'(1))); // R7
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_we) |=> $stable(q.count)); // R7
    AST_EVT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !intv_we) |=> (q.since == '0)); // R8

endmodule

// File: rtl/idxwin_file.sv
module idxwin_file #(
    parameter int DEPTH = 64,
    parameter int CHANS = 4,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [$clog2(CHANS)-1:0] chan,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);

    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(CHANS);
    localparam int WORDS = DEPTH * CHANS;

    logic [DW-1:0]    mem_q [WORDS];
    logic [DW-1:0]    mem_d [WORDS];
    logic [AW+CW-1:0] idx;

    assign idx   = {addr, chan};
    assign rdata = mem_q[idx];

    always_comb begin
        for (int i = 0; i < WORDS; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[idx] = wdata;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    AST_FILE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(idx)] == $past(wdata))); // R3

endmodule

// File: rtl/idxwin_pend.sv
module idxwin_pend #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic [W-1:0] en_vec,
    output logic [W-1:0] pend,
    output logic         irq
);

    logic [W-1:0] pend_q, pend_d;

    always_comb begin
        pend_d = (pend_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
    assign irq  = |(pend_q & en_vec);

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec))); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0)); // R5
    AST_W1C_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~clr_vec) != '0) |=>
            ((pend_q & $past(pend_q & ~clr_vec)) == $past(pend_q & ~clr_vec))); // R5

endmodule

// File: rtl/idxwin_top.sv
module idxwin_top
    import idxwin_pkg::*;
#(
    parameter int IDX_DEPTH = 64,
    parameter int CNT_W     = 22
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [2:0]  bus_word,
    input  logic [1:0]  bus_half_en,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] ext_evt,
    input  logic        tick_fast,
    input  logic        tick_slow,
    output logic        irq
);

    localparam int AW = $clog2(IDX_DEPTH);

    win_st_t       q, d;
    logic          wr, rd, in_file, file_we;
    logic          fast_cnt_we, slow_cnt_we, fast_int_we, slow_int_we;
    logic          fast_evt, slow_evt;
    logic [DW-1:0] hmask, set_vec, clr_vec, pend, file_rdata, idx_rd;
    logic [CNT_W-1:0] fast_cnt, slow_cnt, fast_int, slow_int;

    // access decode
    always_comb begin
        wr      = bus_valid && bus_write;
        rd      = bus_valid && !bus_write;
        hmask   = {{16{bus_half_en[1]}}, {16{bus_half_en[0]}}};
        in_file = q.ptr.addr < PA_W'(IDX_DEPTH);
        file_we     = wr && (bus_word == W_DATA) && in_file;
        fast_cnt_we = wr && (bus_word == W_DATA) && (q.ptr.addr == IX_CNT_FAST);
        slow_cnt_we = wr && (bus_word == W_DATA) && (q.ptr.addr == IX_CNT_SLOW);
        fast_int_we = wr && (bus_word == W_DATA) && (q.ptr.addr == IX_INTERVAL) && (q.ptr.chan == 2'd0);
        slow_int_we = wr && (bus_word == W_DATA) && (q.ptr.addr == IX_INTERVAL) && (q.ptr.chan == 2'd1);
        clr_vec = (wr && (bus_word == W_PEND)) ? (bus_wdata & hmask) : '0;
        set_vec = ext_evt;
        set_vec[BIT_FAST] = ext_evt[BIT_FAST] | fast_evt;
        set_vec[BIT_SLOW] = ext_evt[BIT_SLOW] | slow_evt;
        if (in_file) begin
            idx_rd = file_rdata;
        end else begin
            case (q.ptr.addr)
                IX_CNT_FAST: idx_rd = DW'(fast_cnt);
                IX_CNT_SLOW: idx_rd = DW'(slow_cnt);
                IX_INTERVAL: idx_rd = (q.ptr.chan == 2'd0) ? DW'(fast_int) :
                                      (q.ptr.chan == 2'd1) ? DW'(slow_int) : '0;
                default:     idx_rd = '0;
            endcase
        end
    end

    // next state
    always_comb begin
        d = q;
        if (wr) begin
            case (bus_word)
                W_PTR: begin
                    if (bus_half_en[0]) d.ptr.chan = bus_wdata[1:0];
                    if (bus_half_en[1]) d.ptr.addr = bus_wdata[27:16];
                end
                W_EN:    d.en  = (q.en  & ~hmask) | (bus_wdata & hmask);
                W_CFG:   d.cfg = (q.cfg & ~hmask) | (bus_wdata & hmask);
                default: ;
            endcase
        end
        if (rd) begin
            case (bus_word)
                W_PTR:   d.rdata = {4'b0, q.ptr.addr, 14'b0, q.ptr.chan};
                W_DATA:  d.rdata = idx_rd;
                W_PEND:  d.rdata = pend;
                W_EN:    d.rdata = q.en;
                W_CFG:   d.rdata = q.cfg;
                default: d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;

    idxwin_file #(.DEPTH(IDX_DEPTH), .CHANS(4), .DW(DW)) i_file (
        .clk(clk), .rst_n(rst_n), .we(file_we),
        .addr(q.ptr.addr[AW-1:0]), .chan(q.ptr.chan),
        .wdata(bus_wdata), .rdata(file_rdata)
    );

    idxwin_timer #(.CNT_W(CNT_W)) i_tmr_fast (
        .clk(clk), .rst_n(rst_n), .tick(tick_fast),
        .cnt_we(fast_cnt_we), .intv_we(fast_int_we), .wdata(bus_wdata[CNT_W-1:0]),
        .count(fast_cnt), .interval(fast_int), .evt(fast_evt)
    );

    idxwin_timer #(.CNT_W(CNT_W)) i_tmr_slow (
        .clk(clk), .rst_n(rst_n), .tick(tick_slow),
        .cnt_we(slow_cnt_we), .intv_we(slow_int_we), .wdata(bus_wdata[CNT_W-1:0]),
        .count(slow_cnt), .interval(slow_int), .evt(slow_evt)
    );

    idxwin_pend #(.W(DW)) i_pend (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .en_vec(q.en), .pend(pend), .irq(irq)
    );

    AST_PTR_HALF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (bus_word == W_PTR) && !bus_half_en[1]) |=> $stable(q.ptr.addr)); // R2
    AST_PTR_LOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (bus_word == W_PTR) && !bus_half_en[0]) |=> $stable(q.ptr.chan)); // R2
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata)); // R1

endmodule

// File: tb/test_idxwin_top.sv
module test_idxwin_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [2:0]  bus_word = '0;
    logic [1:0]  bus_half_en = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ext_evt = '0;
    logic        tick_fast = 1'b0, tick_slow = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    idxwin_top i_idxwin_top (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_word(bus_word), .bus_half_en(bus_half_en), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ext_evt(ext_evt), .tick_fast(tick_fast),
        .tick_slow(tick_slow), .irq(irq)
    );

    // behavioural reference for pending, enable and timer state (drives irq expectation)
    logic [31:0] m_pend, m_en, m_hm, m_clr, m_set;
    int m_chan, m_addr, m_fc, m_sc, m_fs, m_ss, m_fi, m_si;
    bit m_fe, m_se;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_en = 0; m_chan = 0; m_addr = 0;
            m_fc = 0; m_sc = 0; m_fs = 0; m_ss = 0; m_fi = 0; m_si = 0;
        end else begin
            m_hm  = {{16{bus_half_en[1]}}, {16{bus_half_en[0]}}};
            m_fe  = tick_fast && m_fi != 0 && m_fs + 1 == m_fi;
            m_se  = tick_slow && m_si != 0 && m_ss + 1 == m_si;
            m_set = ext_evt;
            if (m_fe) m_set[4] = 1'b1;
            if (m_se) m_set[3] = 1'b1;
            m_clr = 0;
            if (tick_fast) begin m_fc = (m_fc + 1) & 32'h3FFFFF; m_fs = m_fe ? 0 : m_fs + 1; end
            if (tick_slow) begin m_sc = (m_sc + 1) & 32'h3FFFFF; m_ss = m_se ? 0 : m_ss + 1; end
            if (bus_valid && bus_write) begin
                case (bus_word)
                    3'd0: begin
                        if (bus_half_en[0]) m_chan = int'(bus_wdata[1:0]);
                        if (bus_half_en[1]) m_addr = int'(bus_wdata[27:16]);
                    end
                    3'd1: begin
                        if (m_addr == 'h77) m_fc = int'(bus_wdata & 32'h3FFFFF);
                        if (m_addr == 'h78) m_sc = int'(bus_wdata & 32'h3FFFFF);
                        if (m_addr == 'h79 && m_chan == 0) begin m_fi = int'(bus_wdata & 32'h3FFFFF); m_fs = 0; end
                        if (m_addr == 'h79 && m_chan == 1) begin m_si = int'(bus_wdata & 32'h3FFFFF); m_ss = 0; end
                    end
                    3'd2: m_clr = bus_wdata & m_hm;
                    3'd3: m_en  = (m_en & ~m_hm) | (bus_wdata & m_hm);
                    default: ;
                endcase
            end
            m_pend = (m_pend & ~m_clr) | m_set;
        end
    end

    // R9: irq compared with the reference every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (irq !== ((m_pend & m_en) != 0)) begin
                n_fail++;
                $display("FAIL R9 irq actual=%0b expected=%0b", irq, (m_pend & m_en) != 0);
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] dat, input logic [1:0] he = 2'b11);
        bus_valid = 1; bus_write = 1; bus_word = w; bus_wdata = dat; bus_half_en = he;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; bus_half_en = 0;
    endtask

    task automatic rdc(input logic [2:0] w, input logic [31:0] exp, input string tag);
        bus_valid = 1; bus_write = 0; bus_word = w;
        @(negedge clk);
        bus_valid = 0;
        check(bus_rdata, exp, tag);
    endtask

    task automatic setp(input logic [11:0] a, input logic [1:0] c);
        wr(3'd0, {4'b0, a, 14'b0, c});
    endtask

    task automatic ticks(input bit f, input bit s, input int n);
        for (int i = 0; i < n; i++) begin
            tick_fast = f; tick_slow = s;
            @(negedge clk);
        end
        tick_fast = 0; tick_slow = 0;
    endtask

    initial begin
        #(200000 * 8);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state
        rdc(3'd0, 32'h0, "R4 pointer");
        rdc(3'd2, 32'h0, "R4 pending");
        rdc(3'd3, 32'h0, "R4 enable");
        rdc(3'd5, 32'h0, "R4 config");
        setp(12'h000, 2'd0); rdc(3'd1, 32'h0, "R4 idx 00 ch0");
        setp(12'h03F, 2'd3); rdc(3'd1, 32'h0, "R4 idx 3F ch3");
        setp(12'h021, 2'd2); rdc(3'd1, 32'h0, "R4 idx 21 ch2");

        // pointer fields and halves
        wr(3'd0, 32'hFFFF_FFFF); rdc(3'd0, 32'h0FFF_0003, "R2 field mask");
        wr(3'd0, 32'h0000_0001, 2'b01); rdc(3'd0, 32'h0FFF_0001, "R2 low half only");
        wr(3'd0, 32'h0012_0002, 2'b10); rdc(3'd0, 32'h0012_0001, "R2 high half only");

        // data port
        setp(12'h005, 2'd1); wr(3'd1, 32'hDEAD_BEEF, 2'b00);
        rdc(3'd1, 32'hDEAD_BEEF, "R3 full word write");
        setp(12'h005, 2'd2); rdc(3'd1, 32'h0, "R3 channel separate");
        wr(3'd1, 32'h1234_5678); rdc(3'd1, 32'h1234_5678, "R3 channel 2 word");
        setp(12'h005, 2'd1); rdc(3'd1, 32'hDEAD_BEEF, "R3 channel 1 kept");
        setp(12'h040, 2'd0); wr(3'd1, 32'hAAAA_5555); rdc(3'd1, 32'h0, "R3 unmapped index");

        // unmapped slots and read hold
        wr(3'd4, 32'hFFFF_FFFF); rdc(3'd4, 32'h0, "R1 slot 4");
        rdc(3'd7, 32'h0, "R1 slot 7");
        setp(12'h005, 2'd1); rdc(3'd1, 32'hDEAD_BEEF, "R1 data slot");
        repeat (3) @(negedge clk);
        check(bus_rdata, 32'hDEAD_BEEF, "R1 read data held");

        // enable / config storage
        wr(3'd5, 32'hCAFE_F00D); rdc(3'd5, 32'hCAFE_F00D, "R10 config");
        wr(3'd5, 32'h1111_2222, 2'b10); rdc(3'd5, 32'h1111_F00D, "R10 config upper half");
        wr(3'd3, 32'h0000_0000); rdc(3'd3, 32'h0, "R10 enable");

        // events, W1C, irq
        ext_evt = 32'h0000_0080; @(negedge clk); ext_evt = 0;
        rdc(3'd2, 32'h0000_0080, "R6 event sets");
        check({31'b0, irq}, 32'h0, "R9 masked");
        wr(3'd3, 32'h0000_0080);
        check({31'b0, irq}, 32'h1, "R9 enabled");
        wr(3'd2, 32'h0000_0000); rdc(3'd2, 32'h0000_0080, "R5 zero keeps");
        wr(3'd2, 32'h0000_0080); rdc(3'd2, 32'h0, "R5 one clears");
        check({31'b0, irq}, 32'h0, "R9 after clear");
        ext_evt = 32'h0010_0200; @(negedge clk); ext_evt = 0;
        bus_valid = 1; bus_write = 1; bus_word = 3'd2; bus_wdata = 32'h0000_0200; bus_half_en = 2'b11;
        ext_evt = 32'h0000_0200;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; bus_half_en = 0; ext_evt = 0;
        rdc(3'd2, 32'h0010_0200, "R6 event beats clear");
        wr(3'd2, 32'h0010_0000, 2'b01); rdc(3'd2, 32'h0010_0200, "R5 disabled half keeps");
        wr(3'd2, 32'hFFFF_FFFF); rdc(3'd2, 32'h0, "R5 clear all");

        // counters
        ticks(1, 0, 5); ticks(0, 1, 3);
        setp(12'h077, 2'd0); rdc(3'd1, 32'd5, "R7 fast count");
        setp(12'h077, 2'd2); rdc(3'd1, 32'd5, "R7 fast any channel");
        setp(12'h078, 2'd1); rdc(3'd1, 32'd3, "R7 slow count");
        wr(3'd1, 32'hFF3F_FFFE); rdc(3'd1, 32'h003F_FFFE, "R7 load");
        ticks(0, 1, 2);
        setp(12'h078, 2'd3); rdc(3'd1, 32'h0, "R7 wrap");
        rdc(3'd2, 32'h0, "R8 no event with zero interval");

        // intervals
        wr(3'd3, 32'h0000_0018);
        setp(12'h079, 2'd0); wr(3'd1, 32'd3);
        rdc(3'd1, 32'd3, "R8 fast interval readback");
        ticks(1, 0, 2); rdc(3'd2, 32'h0, "R8 one tick before interval");
        ticks(1, 0, 1); rdc(3'd2, 32'h0000_0010, "R8 fast event");
        check({31'b0, irq}, 32'h1, "R9 timer irq");
        wr(3'd2, 32'h0000_0010);
        ticks(1, 0, 2); rdc(3'd2, 32'h0, "R8 restart count");
        ticks(1, 0, 1); rdc(3'd2, 32'h0000_0010, "R8 fast event repeats");
        setp(12'h077, 2'd1); rdc(3'd1, 32'd11, "R7 fast count after events");
        wr(3'd2, 32'hFFFF_FFFF);
        setp(12'h079, 2'd1); wr(3'd1, 32'd2);
        ticks(0, 1, 1); rdc(3'd2, 32'h0, "R8 slow before interval");
        ticks(0, 1, 1); rdc(3'd2, 32'h0000_0008, "R8 slow event");
        wr(3'd3, 32'h0);
        check({31'b0, irq}, 32'h0, "R9 disabled");

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule